// File: doc/BRIEF.md
# Register-Window Serial Port with Transmit Holding Register

This block is an asynchronous serial transmitter and receiver that sits on a narrow CPU bus. The bus sees three registers. Offset 0x00 is the data register: a write hands a byte to the transmitter, and a read returns the last byte received. Offset 0x02 is a read-only status register. Offset 0x1F is the control register, which selects the frame format, the baud rate and the receive interrupt enable.

The transmitter has a one-byte holding register in front of its shift register. A byte written while the line is idle moves to the shift register within a few clocks, and status then reports that the holding register is free. A second byte can then be queued. It follows the first frame with no idle gap. A write to an occupied holding register replaces the queued byte, and no flag records this. Status bits are sticky event flags. Every write to the data register clears them all, and reading status leaves them unchanged.

Both directions share a 16x oversampling tick taken from the bus clock. The receiver confirms a start bit at mid-bit, samples each later bit at its centre, and flags parity errors, framing errors and break. The interrupt output is a level.

Top module: `uart_regwin`

## Requirements
- R1: After reset, status reads 0x86, control reads 0x40, `tx_out` is high and `irq` is low.
- R2: Any write to offset 0x00 clears every status bit. Status reads 0x00 in the cycle after the write.
- R3: Status bit 1 (holding register free) sets a few cycles after the holding register hands its byte to an idle shifter. Status bit 2 (transmitter idle) sets when a frame ends with nothing queued. With an idle transmitter, status reads 0x02 three cycles after a data write.
- R4: A transmitted frame has these parts in order: a low start bit, the data bits LSB first (8 when control bit 6 is 1, otherwise 7), an optional parity bit, and one high stop bit. `tx_out` is high when idle.
- R5: A byte queued while a frame is in progress starts the very next bit period after that frame's stop bit ends.
- R6: A write while the holding register is occupied replaces the queued byte. The earlier queued byte is never sent, and no status bit records the loss.
- R7: A read of offset 0x00 returns the most recently received byte. In 7-bit mode, bit 7 reads 0.
- R8: Control bit 5 enables parity and control bit 4 selects odd (1) or even (0). The transmitter appends the parity bit. The receiver sets status bit 4 when the received parity bit is wrong.
- R9: A received frame whose stop bit samples low sets status bit 5 (framing error).
- R10: A received frame that is entirely low (data, parity and stop) also sets status bit 6 (break). The receiver then waits for the line to return high. After reset, a long low period on `rx_in` changes status from 0x86 to 0xE6.
- R11: Reading status does not change it.
- R12: Status bit 7 (receive attention) is set at reset and by every received frame. `irq` is high exactly while this bit and control bit 7 are both 1, so enabling the interrupt right after reset with an idle line raises `irq` at once.
- R13: Control bits 1:0 select the baud rate. One bit lasts 16 × BASE_DIV × 2^sel clocks. Control bits 3:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not selected or unmapped) |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| irq | output | 1 | Receive interrupt, level |

## Verification
The bench builds the block with BASE_DIV = 2. A bit then lasts 32 clocks at baud select 0 and 64 clocks at select 1. This keeps about twenty frames, a twelve-bit break and both parity senses within a few thousand cycles. A tick every second clock also gives the start-bit phase error a non-zero size, so the back-to-back gap check tests a real alignment window rather than an exact count.

// File: rtl/uart_regwin_pkg.sv
package uart_regwin_pkg;

    // Register window
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h1F;

    // Oversampling and framing
    localparam int OVERSAMPLE = 16;
    localparam int OS_W       = $clog2(OVERSAMPLE);
    localparam int FRAME_MAX  = 11;
    localparam int BSEL_W     = 2;

    // Status bit positions
    localparam int ST_RXATT  = 7;
    localparam int ST_BRK    = 6;
    localparam int ST_FERR   = 5;
    localparam int ST_PERR   = 4;
    localparam int ST_TXIDLE = 2;
    localparam int ST_HFREE  = 1;

    localparam logic [7:0] STATUS_RST = 8'h86;

    typedef struct packed {
        logic              rx_irq_en;   // bit 7
        logic              eight_bit;   // bit 6
        logic              par_en;      // bit 5
        logic              par_odd;     // bit 4
        logic [1:0]        rsvd;        // bits 3:2, read as zero
        logic [BSEL_W-1:0] baud_sel;    // bits 1:0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{rx_irq_en: 1'b0, eight_bit: 1'b1, par_en: 1'b0,
                                   par_odd: 1'b0, rsvd: 2'b00, baud_sel: '0};

    typedef struct packed {
        logic eight_bit;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_result_t;

    typedef struct packed {
        logic hold_free;
        logic tx_idle;
    } tx_event_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_t;

    function automatic logic calc_parity(logic [7:0] d, logic eight, logic odd);
        logic p;
        p = eight ? ^d : ^d[6:0];
        return p ^ odd;
    endfunction

    function automatic logic [3:0] frame_len(logic eight, logic par);
        return 4'd9 + {3'b000, eight} + {3'b000, par};
    endfunction

    // Frame image, LSB goes out first: start, data, [parity], stop, idle fill
    function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, frame_cfg_t c);
        logic [FRAME_MAX-1:0] f;
        logic [3:0]           pos;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 7; i++) f[i+1] = d[i];
        pos = 4'd8;
        if (c.eight_bit) begin
            f[8] = d[7];
            pos  = 4'd9;
        end
        if (c.par_en) f[pos] = calc_parity(d, c.eight_bit, c.par_odd);
        return f;
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick
    import uart_regwin_pkg::*;
#(
    parameter int BASE_DIV = 2604
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BSEL_W-1:0] sel,
    output logic              tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << BSEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_n;

    always_comb begin
        div_n = CNT_W'(BASE_DIV) << sel;
        tick  = (cnt_q >= div_n - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end

    generate
        if (BASE_DIV >= 2) begin : g_gap_chk
            // R13: ticks are never adjacent when the divisor exceeds one
            a_r13_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_out,
    output tx_event_t  ev
);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);

    logic                 hold_full_q;
    logic [7:0]           hold_q;
    logic                 busy_q;
    logic [FRAME_MAX-1:0] shreg_q;
    logic [3:0]           bits_left_q;
    logic [OS_W-1:0]      os_q;

    logic bit_end, last_bit, load;

    always_comb begin
        bit_end      = busy_q && tick && (os_q == OS_LAST);
        last_bit     = bit_end && (bits_left_q == 4'd1);
        load         = hold_full_q && (!busy_q || last_bit);
        ev.hold_free = load;
        ev.tx_idle   = last_bit && !hold_full_q && !wr_en;
        tx_out       = shreg_q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full_q <= 1'b0;
            hold_q      <= '0;
            busy_q      <= 1'b0;
            shreg_q     <= '1;
            bits_left_q <= '0;
            os_q        <= '0;
        end else begin
            if (load) begin
                busy_q      <= 1'b1;
                shreg_q     <= build_frame(hold_q, cfg);
                bits_left_q <= frame_len(cfg.eight_bit, cfg.par_en);
                os_q        <= '0;
            end else if (busy_q && tick) begin
                if (os_q == OS_LAST) begin
                    os_q        <= '0;
                    shreg_q     <= {1'b1, shreg_q[FRAME_MAX-1:1]};
                    bits_left_q <= bits_left_q - 4'd1;
                    if (bits_left_q == 4'd1) busy_q <= 1'b0;
                end else begin
                    os_q <= os_q + OS_W'(1);
                end
            end
            // A new write always wins the holding slot (replaces a queued byte)
            if (wr_en) begin
                hold_full_q <= 1'b1;
                hold_q      <= wr_data;
            end else if (load) begin
                hold_full_q <= 1'b0;
            end
        end
    end

    // R4: line rests high between frames
    a_r4_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> tx_out);

    // R5: a queued byte starts with its start bit right after the stop bit
    a_r5_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (last_bit && hold_full_q) |=> (busy_q && !tx_out));
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rx_in,
    output logic       done,
    output rx_result_t res
);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0] OS_HALF = OS_W'(OVERSAMPLE / 2 - 1);

    logic       sync1_q, rx_s;
    rx_state_t  state_q;
    logic [OS_W-1:0] os_q;
    logic [2:0] idx_q;
    logic [7:0] shift_q;
    logic       par_q;
    logic       done_q;
    rx_result_t res_q;
    logic [2:0] last_idx;

    assign last_idx = cfg.eight_bit ? 3'd7 : 3'd6;
    assign done     = done_q;
    assign res      = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            sync1_q <= rx_in;
            rx_s    <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            os_q    <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    RX_IDLE: if (!rx_s) begin
                        state_q <= RX_START;
                        os_q    <= '0;
                    end
                    RX_START: begin
                        if (os_q == OS_HALF) begin
                            os_q <= '0;
                            if (!rx_s) begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                shift_q <= '0;
                                par_q   <= 1'b0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (os_q == OS_LAST) begin
                            os_q           <= '0;
                            shift_q[idx_q] <= rx_s;
                            if (idx_q == last_idx)
                                state_q <= cfg.par_en ? RX_PAR : RX_STOP;
                            else
                                idx_q <= idx_q + 3'd1;
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                    RX_PAR: begin
                        if (os_q == OS_LAST) begin
                            os_q    <= '0;
                            par_q   <= rx_s;
                            state_q <= RX_STOP;
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (os_q == OS_LAST) begin
                            os_q          <= '0;
                            done_q        <= 1'b1;
                            res_q.data    <= shift_q;
                            res_q.frm_err <= !rx_s;
                            res_q.par_err <= cfg.par_en &&
                                (par_q != calc_parity(shift_q, cfg.eight_bit, cfg.par_odd));
                            res_q.brk     <= !rx_s && (shift_q == 8'h00) &&
                                             (!cfg.par_en || !par_q);
                            state_q       <= rx_s ? RX_IDLE : RX_HOLD;
                        end else begin
                            os_q <= os_q + OS_W'(1);
                        end
                    end
                    RX_HOLD: if (rx_s) state_q <= RX_IDLE;
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R10: a break is always also a framing error
    a_r10_break_implies_framing: assert property (@(posedge clk) disable iff (rst)
        (done_q && res_q.brk) |-> res_q.frm_err);

    // R7: each received frame reports exactly once
    a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/uart_regwin.sv
module uart_regwin
    import uart_regwin_pkg::*;
#(
    parameter int BASE_DIV = 2604
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_in,
    output logic              tx_out,
    output logic              irq
);
    ctrl_t      ctrl_q;
    logic [7:0] status_q;
    logic [7:0] ev_set;
    frame_cfg_t fcfg;
    logic       tick;
    logic       wr_data, wr_ctrl, rd_stat;
    tx_event_t  tx_ev;
    logic       rx_done;
    rx_result_t rx_res;

    always_comb begin
        wr_data = bus_sel && bus_we && (bus_addr == OFS_DATA);
        wr_ctrl = bus_sel && bus_we && (bus_addr == OFS_CTRL);
        rd_stat = bus_sel && !bus_we && (bus_addr == OFS_STAT);
        fcfg    = '{eight_bit: ctrl_q.eight_bit, par_en: ctrl_q.par_en,
                    par_odd: ctrl_q.par_odd};
    end

    uart_baud_tick #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .sel (ctrl_q.baud_sel),
        .tick(tick)
    );

    uart_tx_path u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cfg    (fcfg),
        .wr_en  (wr_data),
        .wr_data(bus_wdata),
        .tx_out (tx_out),
        .ev     (tx_ev)
    );

    uart_rx_path u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cfg  (fcfg),
        .rx_in(rx_in),
        .done (rx_done),
        .res  (rx_res)
    );

    always_comb begin
        ev_set            = '0;
        ev_set[ST_RXATT]  = rx_done;
        ev_set[ST_BRK]    = rx_done && rx_res.brk;
        ev_set[ST_FERR]   = rx_done && rx_res.frm_err;
        ev_set[ST_PERR]   = rx_done && rx_res.par_err;
        ev_set[ST_TXIDLE] = tx_ev.tx_idle;
        ev_set[ST_HFREE]  = tx_ev.hold_free;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            status_q <= STATUS_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_t'(bus_wdata);
                ctrl_q.rsvd <= 2'b00;
            end
            status_q <= (wr_data ? 8'h00 : status_q) | ev_set;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = rx_res.data;
                OFS_STAT: bus_rdata = status_q;
                OFS_CTRL: bus_rdata = ctrl_q;
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq = ctrl_q.rx_irq_en && status_q[ST_RXATT];

    // R2: a data write leaves no receive flag behind unless a frame lands that cycle
    a_r2_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !rx_done) |=> (status_q[7:4] == 4'h0));

    // R11: a status read with no event and no write leaves status unchanged
    a_r11_status_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rx_done && !tx_ev.hold_free && !tx_ev.tx_idle) |=> $stable(status_q));

    // R12: the interrupt rises only after an enable write or a received frame
    a_r12_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (ctrl_q.rx_irq_en && ($past(wr_ctrl) || $past(rx_done))));
endmodule

// File: tb/tb_uart_regwin.sv
module tb_uart_regwin;
    import uart_regwin_pkg::*;

    localparam int BASE_DIV = 2;
    localparam int BIT_CLKS = 16 * BASE_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_in = 1'b1;
    logic       tx_out, irq;

    always #2 clk = ~clk;   // 250 MHz

    uart_regwin #(.BASE_DIV(BASE_DIV)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in(rx_in), .tx_out(tx_out), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] d;
        bit         eight;
        bit         par_en;
        bit         odd;
        int         bclk;
        bit         b2b;
        string      tag;
    } txexp_t;

    txexp_t exp_q[$];
    bit     mon_busy = 1'b0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic bus_wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Called at a negedge; samples without crossing a clock edge
    task automatic bus_rd(logic [4:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_tx(logic [7:0] d, bit eight, bit par_en, bit odd, int bclk,
                             bit b2b, string tag);
        txexp_t it;
        it.d = d; it.eight = eight; it.par_en = par_en; it.odd = odd;
        it.bclk = bclk; it.b2b = b2b; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_tx(int bclk);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (bclk) @(negedge clk);
    endtask

    task automatic rx_frame(logic [7:0] d, bit eight, bit par_en, bit par_val, bit stop_val);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < (eight ? 8 : 7); i++) begin
            rx_in = d[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        if (par_en) begin
            rx_in = par_val;
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx_in = stop_val;
        repeat (BIT_CLKS) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes the serial line and compares with the queue
    initial begin : tx_monitor
        txexp_t     it;
        logic [7:0] got;
        logic       st, pb, sb, ep;
        int         nb, len, t0;
        int         last_t0, last_len, last_bclk;
        last_t0 = -100000; last_len = 0; last_bclk = BIT_CLKS;
        forever begin
            @(negedge clk);
            if (!rst && tx_out === 1'b0) begin
                t0 = cyc;
                mon_busy = 1'b1;
                if (exp_q.size() == 0) begin
                    check("R4", "unexpected frame", 1, 0);
                    it.d = 8'h00; it.eight = 1'b1; it.par_en = 1'b0; it.odd = 1'b0;
                    it.bclk = BIT_CLKS; it.b2b = 1'b0; it.tag = "R4";
                end else begin
                    it = exp_q.pop_front();
                end
                repeat (it.bclk / 2) @(negedge clk);
                st  = tx_out;
                nb  = it.eight ? 8 : 7;
                got = 8'h00;
                for (int i = 0; i < nb; i++) begin
                    repeat (it.bclk) @(negedge clk);
                    got[i] = tx_out;
                end
                pb = 1'b0;
                if (it.par_en) begin
                    repeat (it.bclk) @(negedge clk);
                    pb = tx_out;
                end
                repeat (it.bclk) @(negedge clk);
                sb  = tx_out;
                len = 2 + nb + (it.par_en ? 1 : 0);
                check("R4", "start bit", st, 0);
                check(it.tag, "tx data", got, it.eight ? it.d : (it.d & 8'h7F));
                if (it.par_en) begin
                    ep = 1'b0;
                    for (int i = 0; i < nb; i++) ep ^= it.d[i];
                    if (it.odd) ep = ~ep;
                    check("R8", "tx parity bit", pb, ep);
                end
                check("R4", "stop bit", sb, 1);
                if (it.b2b)
                    check("R5", "start-to-start gap in window",
                          ((t0 - last_t0) >= last_len * last_bclk - BASE_DIV) &&
                          ((t0 - last_t0) <= last_len * last_bclk), 1);
                last_t0 = t0; last_len = len; last_bclk = it.bclk;
                mon_busy = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [7:0] s, d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_rd(OFS_STAT, s); check("R1", "status reset", s, 8'h86);
        bus_rd(OFS_CTRL, s); check("R1", "control reset", s, 8'h40);
        check("R1", "tx idle high", tx_out, 1);
        check("R1", "irq low", irq, 0);

        // R12: enabling the interrupt with the line idle raises it at once
        bus_wr(OFS_CTRL, 8'hC0);
        check("R12", "irq after enable", irq, 1);

        // R10: long break from reset state
        @(negedge clk); rx_in = 1'b0;
        repeat (12 * BIT_CLKS) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        bus_rd(OFS_STAT, s); check("R10", "status after break", s, 8'hE6);
        repeat (3) @(negedge clk);
        // R11: reading status again leaves it alone
        bus_rd(OFS_STAT, s); check("R11", "status reread", s, 8'hE6);

        // R13: reserved control bits read zero; interrupt off
        bus_wr(OFS_CTRL, 8'h4C);
        bus_rd(OFS_CTRL, s); check("R13", "reserved ctrl bits", s, 8'h40);
        check("R12", "irq after disable", irq, 0);

        // R2/R3: single byte 8N1
        expect_tx(8'hA5, 1, 0, 0, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'hA5);
        bus_rd(OFS_STAT, s); check("R2", "status right after write", s, 8'h00);
        repeat (3) @(negedge clk);
        bus_rd(OFS_STAT, s); check("R3", "holding free soon after", s, 8'h02);
        wait_tx(BIT_CLKS);
        bus_rd(OFS_STAT, s); check("R3", "status after frame", s, 8'h06);

        // R5: queued byte goes out back to back
        expect_tx(8'h55, 1, 0, 0, BIT_CLKS, 0, "R5");
        expect_tx(8'hAA, 1, 0, 0, BIT_CLKS, 1, "R5");
        bus_wr(OFS_DATA, 8'h55);
        do begin @(negedge clk); bus_rd(OFS_STAT, s); end while (s[1] == 1'b0);
        bus_wr(OFS_DATA, 8'hAA);
        wait_tx(BIT_CLKS);

        // R6: overwrite of a queued byte
        expect_tx(8'h11, 1, 0, 0, BIT_CLKS, 0, "R6");
        expect_tx(8'h33, 1, 0, 0, BIT_CLKS, 1, "R6");
        bus_wr(OFS_DATA, 8'h11);
        do begin @(negedge clk); bus_rd(OFS_STAT, s); end while (s[1] == 1'b0);
        bus_wr(OFS_DATA, 8'h22);
        bus_wr(OFS_DATA, 8'h33);
        bus_rd(OFS_STAT, s); check("R6", "no flag on overwrite", s, 8'h00);
        wait_tx(BIT_CLKS);
        bus_rd(OFS_STAT, s); check("R6", "final status", s, 8'h06);

        // R8: 7-bit even and odd parity on transmit
        bus_wr(OFS_CTRL, 8'h20);
        expect_tx(8'h5B, 0, 1, 0, BIT_CLKS, 0, "R8");
        bus_wr(OFS_DATA, 8'h5B);
        wait_tx(BIT_CLKS);
        bus_wr(OFS_CTRL, 8'h30);
        expect_tx(8'h3C, 0, 1, 1, BIT_CLKS, 0, "R8");
        bus_wr(OFS_DATA, 8'h3C);
        wait_tx(BIT_CLKS);

        // R13: baud select 1 doubles the bit time
        bus_wr(OFS_CTRL, 8'h41);
        expect_tx(8'hC3, 1, 0, 0, 2 * BIT_CLKS, 0, "R13");
        bus_wr(OFS_DATA, 8'hC3);
        wait_tx(2 * BIT_CLKS);

        // R7: good 8N1 receive
        bus_wr(OFS_CTRL, 8'h40);
        expect_tx(8'h01, 1, 0, 0, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'h01);
        rx_frame(8'h3C, 1, 0, 0, 1);
        bus_rd(OFS_DATA, d); check("R7", "rx data 8N1", d, 8'h3C);
        bus_rd(OFS_STAT, s); check("R7", "rx flags clean", s & 8'hF0, 8'h80);
        wait_tx(BIT_CLKS);

        // R8: 7-bit even parity, wrong parity bit
        bus_wr(OFS_CTRL, 8'h20);
        expect_tx(8'h02, 0, 1, 0, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'h02);
        rx_frame(8'h41, 0, 1, 1, 1);
        bus_rd(OFS_DATA, d); check("R7", "rx data 7-bit", d, 8'h41);
        bus_rd(OFS_STAT, s); check("R8", "parity error flag", s & 8'hF0, 8'h90);
        wait_tx(BIT_CLKS);

        // R8: 7-bit odd parity, correct parity bit
        bus_wr(OFS_CTRL, 8'h30);
        expect_tx(8'h03, 0, 1, 1, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'h03);
        rx_frame(8'h41, 0, 1, 1, 1);
        bus_rd(OFS_STAT, s); check("R8", "odd parity accepted", s & 8'hF0, 8'h80);
        wait_tx(BIT_CLKS);

        // R9: stop bit low
        bus_wr(OFS_CTRL, 8'h40);
        expect_tx(8'h04, 1, 0, 0, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'h04);
        rx_frame(8'h96, 1, 0, 0, 0);
        bus_rd(OFS_DATA, d); check("R9", "rx data with bad stop", d, 8'h96);
        bus_rd(OFS_STAT, s); check("R9", "framing flag only", s & 8'hF0, 8'hA0);
        wait_tx(BIT_CLKS);

        // R12: pending receive raises irq once enabled; data write drops it
        bus_wr(OFS_CTRL, 8'hC0);
        check("R12", "irq with pending rx", irq, 1);
        expect_tx(8'h0F, 1, 0, 0, BIT_CLKS, 0, "R4");
        bus_wr(OFS_DATA, 8'h0F);
        check("R12", "irq after data write", irq, 0);
        wait_tx(BIT_CLKS);

        summary();
        $finish;
    end
endmodule